// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Assigner

This block attaches four voice channels to a framed serial TDM PCM bus that runs from a single bit clock. A frame strobe restarts a bit and slot counter. Every slot lasts eight bit clocks, and a frame can hold up to 256 slots. Each channel has its own transmit slot and its own receive slot, and each direction has its own enable. In an owned transmit slot the block shifts out the channel's 8-bit sample, most significant bit first, and raises an output enable. In every other bit period the enable stays low, so the pad can be released. Because of this, the transmit and receive lines of many devices can be tied together to form a single two-wire bus.

Incoming bus bits are sampled on the falling edge of the bit clock. At the end of a channel's receive slot, the completed byte is handed to that channel with a one-cycle valid pulse. Transmit samples are taken from all channels at the frame strobe, and an enabled channel sees a one-cycle take pulse that tells it to prepare the next sample. Slot assignments are written through a simple register port into a shadow copy. The shadow copy becomes live only at the next frame strobe, so no frame is ever served with a partly updated assignment.

Top module: `pcm_slot_mapper`

## Requirements
- R1: When the frame strobe is sampled high on a rising bit-clock edge, the following bit period is bit 0 of slot 0. Each slot is exactly 8 bit periods long, and without a strobe the count wraps after 2^SLOT_W slots.
- R2: In all 8 bit periods of a slot equal to an enabled channel's active transmit slot, tx_oe_o is high and tx_d_o carries that channel's latched byte, most significant bit in bit 0. The data changes only after rising edges.
- R3: In any bit period whose slot is not owned by an enabled transmit channel, tx_oe_o is low and tx_d_o is 0.
- R4: When several enabled channels share a transmit slot, the lowest-numbered one drives. conflict_o is high for exactly the frames whose active assignment contains such a sharing.
- R5: rx_d_i is sampled on falling edges, most significant bit first. In the bit period right after the last bit of an enabled channel's receive slot, that channel's rx_valid_o bit is high for one cycle and its rx_sample_o slice holds the received byte.
- R6: Several enabled channels that share one receive slot all capture the same byte.
- R7: A channel whose transmit enable is clear never drives the bus. A channel whose receive enable is clear never pulses rx_valid_o and never changes its rx_sample_o slice.
- R8: At the rising edge where the frame strobe is sampled, the block latches every channel's tx_sample_i slice (channel c at bits 8c+7..8c). In bit 0 of slot 0, tx_take_o is high exactly for the channels whose transmit enable is active.
- R9: A write with cfg_we_i high stores the transmit slot, receive slot and both enables of channel cfg_ch_i. The write changes the bus behaviour only from the next frame strobe onwards, never in the current frame.
- R10: While rst_n is low, all outputs are 0 and all channels are disabled. After reset, nothing is driven or captured until a channel is configured and a strobe has occurred.
- R11: Frames shorter than 2^SLOT_W slots, ended early by the strobe, and a full frame that uses slot 255 both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the PCM bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | Frame strobe, one bit period high, before bit 0 of slot 0 |
| tx_d_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit pad enable |
| rx_d_i | input | 1 | Serial receive data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel selected by the write |
| cfg_tx_slot_i | input | SLOT_W | Transmit slot number to store |
| cfg_rx_slot_i | input | SLOT_W | Receive slot number to store |
| cfg_tx_en_i | input | 1 | Transmit enable to store |
| cfg_rx_en_i | input | 1 | Receive enable to store |
| tx_sample_i | input | 8*NUM_CH | Per-channel transmit samples |
| tx_take_o | output | NUM_CH | Per-channel sample-taken pulse |
| rx_sample_o | output | 8*NUM_CH | Per-channel received samples |
| rx_valid_o | output | NUM_CH | Per-channel received-sample pulse |
| conflict_o | output | 1 | Active assignment has a shared transmit slot |

## Verification
The main function is exercised with four frame patterns. The first uses distinct transmit slots and two channels that share a receive slot, which separates slot decoding from channel selection. The second has three enabled transmitters, two of which share a slot, plus a disabled channel on that same slot, which checks the priority order, the conflict flag and the transmit enable. The third sets every slot to the same value with all enables off, and the fourth places owners on the first and last slots of a short frame to expose off-by-one errors in the counter. Directed runs then move a slot in the middle of a frame to show the deferral, use slot 255 of a full 256-slot frame, and apply reset while the block is in operation.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
  localparam int unsigned BITS_PER_SLOT = 8;
  localparam int unsigned BIT_W = $clog2(BITS_PER_SLOT);
  typedef logic [BIT_W-1:0] bit_idx_t;
  typedef logic [BITS_PER_SLOT-1:0] sample_t;
endpackage

// File: rtl/tsa_frame_counter.sv
module tsa_frame_counter
  import pcm_tsa_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  output bit_idx_t          bit_idx_o,
  output logic [SLOT_W-1:0] slot_idx_o
);
  localparam int POS_W = SLOT_W + BIT_W;

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    if (fs_i) pos_d = '0;
    else      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign bit_idx_o  = pos_q[BIT_W-1:0];
  assign slot_idx_o = pos_q[POS_W-1:BIT_W];
endmodule

// File: rtl/tsa_cfg_regs.sv
module tsa_cfg_regs #(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 8,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fs_i,
  input  logic                     cfg_we_i,
  input  logic [CH_W-1:0]          cfg_ch_i,
  input  logic [SLOT_W-1:0]        cfg_tx_slot_i,
  input  logic [SLOT_W-1:0]        cfg_rx_slot_i,
  input  logic                     cfg_tx_en_i,
  input  logic                     cfg_rx_en_i,
  output logic [NUM_CH*SLOT_W-1:0] act_tx_slot_o,
  output logic [NUM_CH*SLOT_W-1:0] act_rx_slot_o,
  output logic [NUM_CH-1:0]        act_tx_en_o,
  output logic [NUM_CH-1:0]        act_rx_en_o,
  output logic                     conflict_o
);
  logic [SLOT_W-1:0] sh_txs [NUM_CH];
  logic [SLOT_W-1:0] sh_rxs [NUM_CH];
  logic [NUM_CH-1:0] sh_txe, sh_rxe;
  logic [SLOT_W-1:0] ac_txs [NUM_CH];
  logic [SLOT_W-1:0] ac_rxs [NUM_CH];
  logic [NUM_CH-1:0] ac_txe, ac_rxe;
  logic [NUM_CH-1:0] wr_hit;
  logic              conf_d, conf_q;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      wr_hit[c] = cfg_we_i && (cfg_ch_i == CH_W'(c));
  end

  // shadow copy: written any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        sh_txs[c] <= '0;
        sh_rxs[c] <= '0;
      end
      sh_txe <= '0;
      sh_rxe <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_hit[c]) begin
          sh_txs[c] <= cfg_tx_slot_i;
          sh_rxs[c] <= cfg_rx_slot_i;
          sh_txe[c] <= cfg_tx_en_i;
          sh_rxe[c] <= cfg_rx_en_i;
        end
      end
    end
  end

  // shared transmit slot among enabled channels of the shadow copy
  always_comb begin
    conf_d = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      for (int j = i + 1; j < NUM_CH; j++)
        if (sh_txe[i] && sh_txe[j] && (sh_txs[i] == sh_txs[j]))
          conf_d = 1'b1;
  end

  // active copy: loaded only at the frame strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ac_txs[c] <= '0;
        ac_rxs[c] <= '0;
      end
      ac_txe <= '0;
      ac_rxe <= '0;
      conf_q <= 1'b0;
    end else if (fs_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ac_txs[c] <= sh_txs[c];
        ac_rxs[c] <= sh_rxs[c];
      end
      ac_txe <= sh_txe;
      ac_rxe <= sh_rxe;
      conf_q <= conf_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign act_tx_slot_o[c*SLOT_W +: SLOT_W] = ac_txs[c];
    assign act_rx_slot_o[c*SLOT_W +: SLOT_W] = ac_rxs[c];
  end
  assign act_tx_en_o = ac_txe;
  assign act_rx_en_o = ac_rxe;
  assign conflict_o  = conf_q;
endmodule

// File: rtl/tsa_tx_path.sv
module tsa_tx_path
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 8,
  parameter int CH_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fs_i,
  input  bit_idx_t                        bit_idx_i,
  input  logic [SLOT_W-1:0]               slot_idx_i,
  input  logic [NUM_CH*SLOT_W-1:0]        act_tx_slot_i,
  input  logic [NUM_CH-1:0]               act_tx_en_i,
  input  logic [NUM_CH*BITS_PER_SLOT-1:0] tx_sample_i,
  output logic                            tx_d_o,
  output logic                            tx_oe_o,
  output logic [NUM_CH-1:0]               tx_take_o
);
  sample_t           hold_q [NUM_CH];
  logic              fs_q;
  logic [NUM_CH-1:0] hit;
  logic [CH_W-1:0]   sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) hold_q[c] <= '0;
    end else if (fs_i) begin
      for (int c = 0; c < NUM_CH; c++)
        hold_q[c] <= tx_sample_i[c*BITS_PER_SLOT +: BITS_PER_SLOT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fs_i;
  end

  // lowest-numbered enabled owner wins
  always_comb begin
    sel = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      hit[c] = act_tx_en_i[c] && (act_tx_slot_i[c*SLOT_W +: SLOT_W] == slot_idx_i);
      if (hit[c]) sel = CH_W'(c);
    end
  end

  assign tx_oe_o   = |hit;
  assign tx_d_o    = tx_oe_o & hold_q[sel][~bit_idx_i];
  assign tx_take_o = fs_q ? act_tx_en_i : '0;
endmodule

// File: rtl/tsa_rx_path.sv
module tsa_rx_path
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_d_i,
  input  bit_idx_t                        bit_idx_i,
  input  logic [SLOT_W-1:0]               slot_idx_i,
  input  logic [NUM_CH*SLOT_W-1:0]        act_rx_slot_i,
  input  logic [NUM_CH-1:0]               act_rx_en_i,
  output logic [NUM_CH*BITS_PER_SLOT-1:0] rx_sample_o,
  output logic [NUM_CH-1:0]               rx_valid_o
);
  localparam bit_idx_t LAST_BIT = bit_idx_t'(BITS_PER_SLOT - 1);

  logic                       rx_bit_q;
  logic [BITS_PER_SLOT-2:0]   shift_q, shift_d;
  sample_t                    cap_byte;
  logic [NUM_CH-1:0]          cap_hit;
  logic [NUM_CH-1:0]          valid_q;
  sample_t                    samp_q [NUM_CH];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_bit_q <= 1'b0;
    else        rx_bit_q <= rx_d_i;
  end

  // one bus-wide shifter serves every channel
  assign shift_d  = {shift_q[BITS_PER_SLOT-3:0], rx_bit_q};
  assign cap_byte = {shift_q, rx_bit_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      cap_hit[c] = act_rx_en_i[c] && (bit_idx_i == LAST_BIT) &&
                   (act_rx_slot_i[c*SLOT_W +: SLOT_W] == slot_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int c = 0; c < NUM_CH; c++) samp_q[c] <= '0;
    end else begin
      valid_q <= cap_hit;
      for (int c = 0; c < NUM_CH; c++)
        if (cap_hit[c]) samp_q[c] <= cap_byte;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign rx_sample_o[c*BITS_PER_SLOT +: BITS_PER_SLOT] = samp_q[c];
  end
  assign rx_valid_o = valid_q;
endmodule

// File: rtl/pcm_slot_mapper.sv
module pcm_slot_mapper
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SMP_W = NUM_CH * BITS_PER_SLOT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  output logic              tx_d_o,
  output logic              tx_oe_o,
  input  logic              rx_d_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [SLOT_W-1:0] cfg_tx_slot_i,
  input  logic [SLOT_W-1:0] cfg_rx_slot_i,
  input  logic              cfg_tx_en_i,
  input  logic              cfg_rx_en_i,
  input  logic [SMP_W-1:0]  tx_sample_i,
  output logic [NUM_CH-1:0] tx_take_o,
  output logic [SMP_W-1:0]  rx_sample_o,
  output logic [NUM_CH-1:0] rx_valid_o,
  output logic              conflict_o
);
  logic                     rst_meta_n, rst_sync_n;
  bit_idx_t                 bit_idx;
  logic [SLOT_W-1:0]        slot_idx;
  logic [NUM_CH*SLOT_W-1:0] act_tx_slot, act_rx_slot;
  logic [NUM_CH-1:0]        act_tx_en, act_rx_en;
  logic [2*NUM_CH*SLOT_W+2*NUM_CH-1:0] act_cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  tsa_frame_counter #(.SLOT_W(SLOT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fs_i       (fs_i),
    .bit_idx_o  (bit_idx),
    .slot_idx_o (slot_idx)
  );

  tsa_cfg_regs #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_W(CH_W)) cfg_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fs_i          (fs_i),
    .cfg_we_i      (cfg_we_i),
    .cfg_ch_i      (cfg_ch_i),
    .cfg_tx_slot_i (cfg_tx_slot_i),
    .cfg_rx_slot_i (cfg_rx_slot_i),
    .cfg_tx_en_i   (cfg_tx_en_i),
    .cfg_rx_en_i   (cfg_rx_en_i),
    .act_tx_slot_o (act_tx_slot),
    .act_rx_slot_o (act_rx_slot),
    .act_tx_en_o   (act_tx_en),
    .act_rx_en_o   (act_rx_en),
    .conflict_o    (conflict_o)
  );

  tsa_tx_path #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_W(CH_W)) tx_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fs_i          (fs_i),
    .bit_idx_i     (bit_idx),
    .slot_idx_i    (slot_idx),
    .act_tx_slot_i (act_tx_slot),
    .act_tx_en_i   (act_tx_en),
    .tx_sample_i   (tx_sample_i),
    .tx_d_o        (tx_d_o),
    .tx_oe_o       (tx_oe_o),
    .tx_take_o     (tx_take_o)
  );

  tsa_rx_path #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) rx_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .rx_d_i        (rx_d_i),
    .bit_idx_i     (bit_idx),
    .slot_idx_i    (slot_idx),
    .act_rx_slot_i (act_rx_slot),
    .act_rx_en_i   (act_rx_en),
    .rx_sample_o   (rx_sample_o),
    .rx_valid_o    (rx_valid_o)
  );

  assign act_cfg = {act_tx_slot, act_rx_slot, act_tx_en, act_rx_en};
endmodule

// File: rtl/pcm_slot_mapper_chk.sv
module pcm_slot_mapper_chk
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 8,
  localparam int CFG_W = 2*NUM_CH*SLOT_W + 2*NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_i,
  input logic              tx_oe_o,
  input logic [NUM_CH-1:0] tx_take_o,
  input logic [NUM_CH-1:0] rx_valid_o,
  input bit_idx_t          bit_idx,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [NUM_CH-1:0] act_tx_en,
  input logic [CFG_W-1:0]  act_cfg
);
  localparam bit_idx_t LAST_BIT = bit_idx_t'(BITS_PER_SLOT - 1);

  AST_FS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fs_i |=> (bit_idx == '0 && slot_idx == '0)); // R1

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_i |=> (bit_idx == bit_idx_t'($past(bit_idx) + 1'b1))); // R1

  AST_OE_WHOLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe_o && bit_idx != LAST_BIT && !fs_i) |=> tx_oe_o); // R2

  AST_NO_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tx_en == '0) |-> !tx_oe_o); // R7

  AST_VALID_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid_o) |-> (bit_idx == '0)); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pulse
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o[c] |=> !rx_valid_o[c]); // R5
  end

  AST_TAKE_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_take_o) |-> $past(fs_i)); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fs_i) |-> $stable(act_cfg)); // R9
endmodule

bind pcm_slot_mapper pcm_slot_mapper_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fs_i       (fs_i),
  .tx_oe_o    (tx_oe_o),
  .tx_take_o  (tx_take_o),
  .rx_valid_o (rx_valid_o),
  .bit_idx    (bit_idx),
  .slot_idx   (slot_idx),
  .act_tx_en  (act_tx_en),
  .act_cfg    (act_cfg)
);

// File: tb/pcm_slot_mapper_tb_top.sv
module pcm_slot_mapper_tb_top;
  localparam int NCH = 4;
  localparam int SW  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              fs_i;
  logic              tx_d_o, tx_oe_o;
  logic              rx_d_i;
  logic              cfg_we_i;
  logic [1:0]        cfg_ch_i;
  logic [SW-1:0]     cfg_tx_slot_i, cfg_rx_slot_i;
  logic              cfg_tx_en_i, cfg_rx_en_i;
  logic [8*NCH-1:0]  tx_sample_i;
  logic [NCH-1:0]    tx_take_o;
  logic [8*NCH-1:0]  rx_sample_o;
  logic [NCH-1:0]    rx_valid_o;
  logic              conflict_o;

  pcm_slot_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .tx_d_o(tx_d_o), .tx_oe_o(tx_oe_o),
    .rx_d_i(rx_d_i), .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i),
    .cfg_tx_slot_i(cfg_tx_slot_i), .cfg_rx_slot_i(cfg_rx_slot_i),
    .cfg_tx_en_i(cfg_tx_en_i), .cfg_rx_en_i(cfg_rx_en_i),
    .tx_sample_i(tx_sample_i), .tx_take_o(tx_take_o),
    .rx_sample_o(rx_sample_o), .rx_valid_o(rx_valid_o), .conflict_o(conflict_o)
  );

  typedef struct packed {
    logic [3:0][7:0] txs;
    logic [3:0][7:0] rxs;
    logic [3:0]      txe;
    logic [3:0]      rxe;
    logic [3:0][7:0] bytes;
    logic [7:0]      seed;
  } vec_t;

  // element 0 of each packed list is channel 0 (rightmost)
  localparam vec_t VECS [4] = '{
    '{ {8'd7, 8'd15, 8'd0, 8'd3}, {8'd14, 8'd1, 8'd5, 8'd5}, 4'hF, 4'hF,
       {8'h01, 8'hFF, 8'h3C, 8'hA5}, 8'd11 },
    '{ {8'd4, 8'd4, 8'd9, 8'd4}, {8'd15, 8'd8, 8'd2, 8'd2}, 4'b1110, 4'b0101,
       {8'h5A, 8'hC3, 8'h7E, 8'h80}, 8'h40 },
    '{ {8'd6, 8'd6, 8'd6, 8'd6}, {8'd6, 8'd6, 8'd6, 8'd6}, 4'h0, 4'h0,
       {8'h44, 8'h33, 8'h22, 8'h11}, 8'h99 },
    '{ {8'd14, 8'd1, 8'd15, 8'd0}, {8'd7, 8'd0, 8'd0, 8'd15}, 4'hF, 4'b1011,
       {8'h69, 8'h96, 8'hFF, 8'h00}, 8'hE7 }
  };

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  int         sh_txs [NCH], sh_rxs [NCH], m_txs [NCH], m_rxs [NCH];
  logic [3:0] sh_txe, sh_rxe, m_txe, m_rxe;
  logic [7:0] m_bytes [NCH];
  logic [7:0] exp_rx [NCH];
  logic       m_conf;
  logic [7:0] cur_seed;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] rxb(input int s);
    return cur_seed + 8'(s) * 8'd29;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      sh_txs[c] = 0; sh_rxs[c] = 0; m_txs[c] = 0; m_rxs[c] = 0;
      m_bytes[c] = 0; exp_rx[c] = 0;
    end
    sh_txe = 0; sh_rxe = 0; m_txe = 0; m_rxe = 0; m_conf = 0;
  endtask

  task automatic set_cfg(input int ch, input int ts, input int rs, input logic te, input logic re);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch);
    cfg_tx_slot_i = 8'(ts); cfg_rx_slot_i = 8'(rs);
    cfg_tx_en_i = te; cfg_rx_en_i = re;
    sh_txs[ch] = ts; sh_rxs[ch] = rs; sh_txe[ch] = te; sh_rxe[ch] = re;
  endtask

  task automatic cfg_write(input int ch, input int ts, input int rs, input logic te, input logic re);
    set_cfg(ch, ts, rs, te, re);
    tick();
    cfg_we_i = 1'b0;
  endtask

  // one frame of nslots slots; optional write into the shadow copy mid-frame
  task automatic run_frame(input int nslots, input bit do_wr, input int wr_k,
                           input int wr_ch, input int wr_ts);
    logic [3:0] vexp;
    int own;
    fs_i = 1'b1;
    tick();
    fs_i = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      m_txs[c] = sh_txs[c]; m_rxs[c] = sh_rxs[c];
      m_bytes[c] = tx_sample_i[8*c +: 8];
    end
    m_txe = sh_txe; m_rxe = sh_rxe; m_conf = 1'b0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (m_txe[i] && m_txe[j] && m_txs[i] == m_txs[j]) m_conf = 1'b1;

    for (int k = 0; k < nslots * 8; k++) begin
      int s, b;
      s = k / 8; b = k % 8;
      cfg_we_i = 1'b0;
      rx_d_i = rxb(s)[7-b];
      own = -1;
      for (int c = NCH - 1; c >= 0; c--)
        if (m_txe[c] && m_txs[c] == s) own = c;
      chk(own >= 0 ? "R2 oe in owned slot" : "R3 oe released", 32'(tx_oe_o), 32'(own >= 0));
      if (own >= 0) chk("R2/R4 tx bit of owner", 32'(tx_d_o), 32'(m_bytes[own][7-b]));
      else          chk("R3 tx data idle", 32'(tx_d_o), 32'd0);
      vexp = '0;
      if (b == 0 && k >= 8)
        for (int c = 0; c < NCH; c++)
          if (m_rxe[c] && m_rxs[c] == s - 1) begin
            vexp[c] = 1'b1;
            exp_rx[c] = rxb(s - 1);
          end
      chk("R5/R6/R7 rx valid", 32'(rx_valid_o), 32'(vexp));
      for (int c = 0; c < NCH; c++)
        if (vexp[c]) chk("R5/R6 rx byte", 32'(rx_sample_o[8*c +: 8]), 32'(exp_rx[c]));
      chk("R8 take pulse", 32'(tx_take_o), k == 0 ? 32'(m_txe) : 32'd0);
      chk("R4 conflict flag", 32'(conflict_o), 32'(m_conf));
      if (do_wr && k == wr_k) set_cfg(wr_ch, wr_ts, sh_rxs[wr_ch], sh_txe[wr_ch], sh_rxe[wr_ch]);
      tick();
    end
    cfg_we_i = 1'b0;
    rx_d_i = 1'b0;
    vexp = '0;
    for (int c = 0; c < NCH; c++)
      if (m_rxe[c] && m_rxs[c] == nslots - 1) begin
        vexp[c] = 1'b1;
        exp_rx[c] = rxb(nslots - 1);
      end
    chk("R5 R11 valid after last slot", 32'(rx_valid_o), 32'(vexp));
    for (int c = 0; c < NCH; c++)
      chk("R7 rx samples held", 32'(rx_sample_o[8*c +: 8]), 32'(exp_rx[c]));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; fs_i = 1'b0; rx_d_i = 1'b0; cfg_we_i = 1'b0; cfg_ch_i = '0;
    cfg_tx_slot_i = '0; cfg_rx_slot_i = '0; cfg_tx_en_i = 1'b0; cfg_rx_en_i = 1'b0;
    tx_sample_i = '0; cur_seed = 8'h00;
    model_reset();
    repeat (3) tick();
    // R10 reset state
    chk("R10 oe in reset", 32'(tx_oe_o), 32'd0);
    chk("R10 valid in reset", 32'(rx_valid_o), 32'd0);
    chk("R10 take in reset", 32'(tx_take_o), 32'd0);
    chk("R10 conflict in reset", 32'(conflict_o), 32'd0);
    chk("R10 samples in reset", 32'(rx_sample_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    cur_seed = 8'h5C;
    run_frame(16, 1'b0, 0, 0, 0); // R10 nothing until configured

    // vector table
    for (int v = 0; v < 4; v++) begin
      tx_sample_i = VECS[v].bytes;
      cur_seed = VECS[v].seed;
      for (int c = 0; c < NCH; c++)
        cfg_write(c, int'(VECS[v].txs[c]), int'(VECS[v].rxs[c]), VECS[v].txe[c], VECS[v].rxe[c]);
      run_frame(16, 1'b0, 0, 0, 0);
    end

    // R9 move channel 3 from slot 14 to slot 5 while the frame runs
    cur_seed = 8'h21;
    tx_sample_i = 32'hC0DE_4A17;
    run_frame(16, 1'b1, 20, 3, 5);
    run_frame(16, 1'b0, 0, 0, 0);

    // R11 full 256-slot frame using slot 255
    cfg_write(0, 128, 0, 1'b1, 1'b0);
    cfg_write(1, 0, 1, 1'b0, 1'b1);
    cfg_write(2, 0, 255, 1'b0, 1'b1);
    cfg_write(3, 255, 0, 1'b1, 1'b0);
    tx_sample_i = 32'hB1_00_00_E3;
    cur_seed = 8'h3A;
    run_frame(256, 1'b0, 0, 0, 0);

    // R10 reset applied during operation
    rst_n = 1'b0;
    #1;
    chk("R10 oe after mid-run reset", 32'(tx_oe_o), 32'd0);
    chk("R10 valid after mid-run reset", 32'(rx_valid_o), 32'd0);
    chk("R10 conflict after mid-run reset", 32'(conflict_o), 32'd0);
    chk("R10 samples after mid-run reset", 32'(rx_sample_o), 32'd0);
    model_reset();
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    cur_seed = 8'hA8;
    run_frame(16, 1'b0, 0, 0, 0);

    done = 1;
    summary();
  end
endmodule